// File: doc/BRIEF.md
# Calendar Clock with Alarm Compare

This block keeps the time of day and the calendar date (seconds, minutes, hours, weekday, day of month, month, two-digit year) and advances them once per second when a one-cycle 1 Hz tick arrives. A host reaches every field through a small indexed register port. Addresses 0 to 9 hold the time fields, with the three alarm bytes placed between them. Address 10 is status, 11 is control and 12 holds the event flags. The host picks per-field BCD or binary encoding and a 12-hour or 24-hour hour format.

Each tick opens an update window. A status bit goes high for a parameterised number of clock cycles before the time registers move, so software can see that a change is on its way. While the window is open, writes to time fields are dropped. At the end of the window the new time is committed in one cycle. The update flag is raised, and the alarm flag is raised as well when seconds, minutes and hours each match their alarm byte. A freeze bit in the control register stops updates so the host can load a new time without racing the tick.

Top module: `calclk_top`

## Requirements
- R1: After reset the time reads 00:00:00, weekday 1, day 1, month 1, year 0 in BCD. The alarm bytes read 0x00, control reads 0x02, status and flags read 0x00, and `irq` is low.
- R2: Host addresses map as follows: 0 seconds, 1 seconds alarm, 2 minutes, 3 minutes alarm, 4 hours, 5 hours alarm, 6 weekday, 7 day of month, 8 month, 9 year. A value written at any of these addresses reads back unchanged.
- R3: Control bit 2 set selects binary encoding and clear selects BCD, for every time field on both read and write. The time is held as a number, so changing the bit alters only the encoding the host sees.
- R4: A tick opens a window. Status bit 7 is high for exactly LEAD_CYCLES cycles, starting the cycle after the tick. The time changes at the edge where that bit falls. A tick that arrives while the window is open has no effect.
- R5: Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry into the date.
- R6: When control bit 1 is clear, the hours register reads 1 to 12 with bit 7 set for PM. The hour 11 PM advances to 12 AM and carries the date, 11 AM advances to 12 PM, and 12 PM advances to 1 PM.
- R7: Weekday runs 1 to 7 and then back to 1. Day of month returns to 1 after the month's last day, which is 30 or 31 days, or for February 29 days when year mod 4 is 0 and 28 days otherwise. Month runs 1 to 12 and year runs 0 to 99.
- R8: At each update the alarm flag (register 12 bit 5) is set when seconds, minutes and hours each either equal their alarm byte in the current encoding or have an alarm byte whose bits 7:6 are both 1.
- R9: Every completed update sets the update flag (register 12 bit 4).
- R10: Register 12 bit 7, and the `irq` output, are high when the update flag is high with control bit 4 set, or when the alarm flag is high with control bit 5 set. Reading address 12 with `host_rd` returns the flags and then clears them. A flag set in that same cycle survives the clear.
- R11: While control bit 7 is set, no update takes place, the status bit stays low, and no flag is raised. Setting the bit during a window cancels that window.
- R12: Host writes to time fields are dropped while the status bit is high. Writes to alarm bytes and to control are still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| host_addr | input | 4 | Register index for read and write |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe; clears the flags when the index is 12 |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for `host_addr`, combinational |
| irq | output | 1 | Enabled flag pending |

## Verification
Two events can fall in the same clock edge: the clear-on-read of the flag register and the commit of an update that sets the update flag. The bench times a flag read so that its strobe is high exactly in the last cycle of the window. That read must return 0x00, and the next read must show the update flag still set. A second overlap, a host write into a time field during the window, is judged by reading back the field after the commit and finding it one second past its old value.

// File: rtl/calclk_pkg.sv
`timescale 1ns/1ps
package calclk_pkg;

    localparam int ADDR_W     = 4;
    localparam int DATA_W     = 8;
    localparam int ALM_FIELDS = 3;

    typedef enum logic [ADDR_W-1:0] {
        RI_SEC      = 4'd0,
        RI_SEC_ALM  = 4'd1,
        RI_MIN      = 4'd2,
        RI_MIN_ALM  = 4'd3,
        RI_HOUR     = 4'd4,
        RI_HOUR_ALM = 4'd5,
        RI_WDAY     = 4'd6,
        RI_MDAY     = 4'd7,
        RI_MON      = 4'd8,
        RI_YEAR     = 4'd9,
        RI_STAT     = 4'd10,
        RI_CTRL     = 4'd11,
        RI_FLAG     = 4'd12
    } reg_idx_e;

    typedef struct packed {
        logic [5:0] sec;
        logic [5:0] min;
        logic [4:0] hour;
        logic [2:0] wday;
        logic [4:0] mday;
        logic [3:0] mon;
        logic [6:0] year;
    } caltime_t;

    typedef struct packed {
        logic freeze;
        logic aie;
        logic uie;
        logic bin;
        logic h24;
    } ctrl_t;

    localparam caltime_t TIME_RESET = '{sec: 6'd0, min: 6'd0, hour: 5'd0,
                                        wday: 3'd1, mday: 5'd1, mon: 4'd1, year: 7'd0};
    localparam ctrl_t    CTRL_RESET = '{freeze: 1'b0, aie: 1'b0, uie: 1'b0,
                                        bin: 1'b0, h24: 1'b1};

    // Number to host byte, BCD or plain binary
    function automatic logic [DATA_W-1:0] to_host(input logic [6:0] v, input logic bin);
        logic [6:0] tens;
        logic [6:0] ones;
        tens = v / 7'd10;
        ones = v - tens * 7'd10;
        return bin ? {1'b0, v} : {tens[3:0], ones[3:0]};
    endfunction

    function automatic logic [6:0] from_host(input logic [DATA_W-1:0] b, input logic bin);
        logic [6:0] r;
        r = 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
        return bin ? b[6:0] : r;
    endfunction

    function automatic logic [DATA_W-1:0] hour_to_host(input logic [4:0] h, input logic bin,
                                                       input logic h24);
        logic [4:0]        h12;
        logic [DATA_W-1:0] e;
        if (h24) return to_host({2'b00, h}, bin);
        if (h == 5'd0)       h12 = 5'd12;
        else if (h > 5'd12)  h12 = h - 5'd12;
        else                 h12 = h;
        e = to_host({2'b00, h12}, bin);
        return {(h >= 5'd12), e[6:0]};
    endfunction

    function automatic logic [4:0] hour_from_host(input logic [DATA_W-1:0] b, input logic bin,
                                                  input logic h24);
        logic [6:0] v;
        if (h24) begin
            v = from_host(b, bin);
            return v[4:0];
        end
        v = from_host({1'b0, b[6:0]}, bin);
        if (v == 7'd12) return b[7] ? 5'd12 : 5'd0;
        return b[7] ? v[4:0] + 5'd12 : v[4:0];
    endfunction

    function automatic logic [4:0] month_len(input logic [3:0] mon, input logic [6:0] year);
        case (mon)
            4'd2:                     return (year[1:0] == 2'b00) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:  return 5'd30;
            default:                  return 5'd31;
        endcase
    endfunction

endpackage

// File: rtl/calclk_advance.sv
`timescale 1ns/1ps
module calclk_advance
    import calclk_pkg::*;
(
    input  caltime_t cur,
    output caltime_t nxt
);
    logic [4:0] last_day;

    assign last_day = month_len(cur.mon, cur.year);

    always_comb begin
        nxt     = cur;
        nxt.sec = cur.sec + 6'd1;
        if (cur.sec >= 6'd59) begin
            nxt.sec = 6'd0;
            nxt.min = cur.min + 6'd1;
            if (cur.min >= 6'd59) begin
                nxt.min  = 6'd0;
                nxt.hour = cur.hour + 5'd1;
                if (cur.hour >= 5'd23) begin
                    nxt.hour = 5'd0;
                    nxt.wday = (cur.wday >= 3'd7) ? 3'd1 : cur.wday + 3'd1;
                    nxt.mday = cur.mday + 5'd1;
                    if (cur.mday >= last_day) begin
                        nxt.mday = 5'd1;
                        nxt.mon  = cur.mon + 4'd1;
                        if (cur.mon >= 4'd12) begin
                            nxt.mon  = 4'd1;
                            nxt.year = (cur.year >= 7'd99) ? 7'd0 : cur.year + 7'd1;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/calclk_alarm.sv
`timescale 1ns/1ps
module calclk_alarm
    import calclk_pkg::*;
(
    input  logic [5:0]        t_sec,
    input  logic [5:0]        t_min,
    input  logic [4:0]        t_hour,
    input  logic              bin,
    input  logic              h24,
    input  logic [DATA_W-1:0] alm_sec,
    input  logic [DATA_W-1:0] alm_min,
    input  logic [DATA_W-1:0] alm_hour,
    output logic              hit
);
    logic [DATA_W-1:0]     now_b [ALM_FIELDS];
    logic [DATA_W-1:0]     alm_b [ALM_FIELDS];
    logic [ALM_FIELDS-1:0] f_hit;

    assign now_b[0] = to_host({1'b0, t_sec}, bin);
    assign now_b[1] = to_host({1'b0, t_min}, bin);
    assign now_b[2] = hour_to_host(t_hour, bin, h24);
    assign alm_b[0] = alm_sec;
    assign alm_b[1] = alm_min;
    assign alm_b[2] = alm_hour;

    for (genvar i = 0; i < ALM_FIELDS; i++) begin : g_field
        assign f_hit[i] = (alm_b[i][7:6] == 2'b11) || (alm_b[i] == now_b[i]);
    end

    assign hit = &f_hit;
endmodule

// File: rtl/calclk_seq.sv
`timescale 1ns/1ps
module calclk_seq #(
    parameter int LEAD_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic freeze,
    output logic uip,
    output logic commit
);
    localparam int CW = (LEAD_CYCLES > 1) ? $clog2(LEAD_CYCLES) : 1;

    logic          busy_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || freeze) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!busy_q) begin
            if (tick) begin
                busy_q <= 1'b1;
                cnt_q  <= CW'(LEAD_CYCLES - 1);
            end
        end else if (cnt_q == '0) begin
            busy_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign uip    = busy_q;
    assign commit = busy_q && (cnt_q == '0) && !freeze;
endmodule

// File: rtl/calclk_top.sv
`timescale 1ns/1ps
module calclk_top
    import calclk_pkg::*;
#(
    parameter int LEAD_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1hz,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              irq
);
    caltime_t          cur_q, nxt_w;
    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] alm_sec_q, alm_min_q, alm_hour_q;
    logic              uf_q, af_q;
    logic              uip_w, commit_w, hit_w, freeze_w, flag_clr, irq_w;
    logic [6:0]        wv;

    assign freeze_w = ctrl_q.freeze;
    assign wv       = from_host(host_wdata, ctrl_q.bin);
    assign flag_clr = host_rd && (host_addr == RI_FLAG);

    calclk_seq #(.LEAD_CYCLES(LEAD_CYCLES)) u_seq (
        .clk(clk), .rst(rst), .tick(tick_1hz), .freeze(freeze_w),
        .uip(uip_w), .commit(commit_w)
    );

    calclk_advance u_adv (.cur(cur_q), .nxt(nxt_w));

    calclk_alarm u_alm (
        .t_sec(nxt_w.sec), .t_min(nxt_w.min), .t_hour(nxt_w.hour),
        .bin(ctrl_q.bin), .h24(ctrl_q.h24),
        .alm_sec(alm_sec_q), .alm_min(alm_min_q), .alm_hour(alm_hour_q),
        .hit(hit_w)
    );

    // Time fields: commit wins, host writes only outside the window
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= TIME_RESET;
        end else if (commit_w) begin
            cur_q <= nxt_w;
        end else if (host_wr && !uip_w) begin
            case (host_addr)
                RI_SEC:  cur_q.sec  <= wv[5:0];
                RI_MIN:  cur_q.min  <= wv[5:0];
                RI_HOUR: cur_q.hour <= hour_from_host(host_wdata, ctrl_q.bin, ctrl_q.h24);
                RI_WDAY: cur_q.wday <= wv[2:0];
                RI_MDAY: cur_q.mday <= wv[4:0];
                RI_MON:  cur_q.mon  <= wv[3:0];
                RI_YEAR: cur_q.year <= wv;
                default: ;
            endcase
        end
    end

    // Alarm bytes and control are always writable
    always_ff @(posedge clk) begin
        if (rst) begin
            alm_sec_q  <= '0;
            alm_min_q  <= '0;
            alm_hour_q <= '0;
            ctrl_q     <= CTRL_RESET;
        end else if (host_wr) begin
            case (host_addr)
                RI_SEC_ALM:  alm_sec_q  <= host_wdata;
                RI_MIN_ALM:  alm_min_q  <= host_wdata;
                RI_HOUR_ALM: alm_hour_q <= host_wdata;
                RI_CTRL: ctrl_q <= '{freeze: host_wdata[7], aie: host_wdata[5],
                                     uie: host_wdata[4], bin: host_wdata[2],
                                     h24: host_wdata[1]};
                default: ;
            endcase
        end
    end

    // Flags: a set in the clearing cycle survives
    always_ff @(posedge clk) begin
        if (rst) begin
            uf_q <= 1'b0;
            af_q <= 1'b0;
        end else begin
            uf_q <= (uf_q && !flag_clr) || commit_w;
            af_q <= (af_q && !flag_clr) || (commit_w && hit_w);
        end
    end

    assign irq_w = (uf_q && ctrl_q.uie) || (af_q && ctrl_q.aie);
    assign irq   = irq_w;

    always_comb begin
        case (host_addr)
            RI_SEC:      host_rdata = to_host({1'b0, cur_q.sec}, ctrl_q.bin);
            RI_SEC_ALM:  host_rdata = alm_sec_q;
            RI_MIN:      host_rdata = to_host({1'b0, cur_q.min}, ctrl_q.bin);
            RI_MIN_ALM:  host_rdata = alm_min_q;
            RI_HOUR:     host_rdata = hour_to_host(cur_q.hour, ctrl_q.bin, ctrl_q.h24);
            RI_HOUR_ALM: host_rdata = alm_hour_q;
            RI_WDAY:     host_rdata = to_host({4'b0, cur_q.wday}, ctrl_q.bin);
            RI_MDAY:     host_rdata = to_host({2'b0, cur_q.mday}, ctrl_q.bin);
            RI_MON:      host_rdata = to_host({3'b0, cur_q.mon}, ctrl_q.bin);
            RI_YEAR:     host_rdata = to_host(cur_q.year, ctrl_q.bin);
            RI_STAT:     host_rdata = {uip_w, 7'b0};
            RI_CTRL:     host_rdata = {ctrl_q.freeze, 1'b0, ctrl_q.aie, ctrl_q.uie,
                                       1'b0, ctrl_q.bin, ctrl_q.h24, 1'b0};
            RI_FLAG:     host_rdata = {irq_w, 1'b0, af_q, uf_q, 4'b0};
            default:     host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/calclk_chk.sv
`timescale 1ns/1ps
module calclk_chk
    import calclk_pkg::*;
#(
    parameter int LEAD_CYCLES = 8
) (
    input logic     clk,
    input logic     rst,
    input logic     uip,
    input logic     freeze,
    input logic     host_wr,
    input caltime_t cur,
    input logic     uf,
    input logic     af
);
    localparam int RW = $clog2(LEAD_CYCLES + 1) + 1;

    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst || !uip) run_q <= '0;
        else             run_q <= run_q + 1'b1;
    end

    AST_WINDOW_LEN: assert property (@(posedge clk) disable iff (rst)
        uip |-> (run_q < RW'(LEAD_CYCLES)));  // R4
    AST_WINDOW_STABLE: assert property (@(posedge clk) disable iff (rst)
        (uip && $past(uip)) |-> $stable(cur));  // R12
    AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        ($past(freeze) && !$past(host_wr)) |-> $stable(cur));  // R11
    AST_FREEZE_NO_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (freeze && $past(freeze)) |-> !uip);  // R11
    AST_UF_AT_UPDATE: assert property (@(posedge clk) disable iff (rst)
        $rose(uf) |-> $past(uip));  // R9
    AST_AF_AT_UPDATE: assert property (@(posedge clk) disable iff (rst)
        $rose(af) |-> $past(uip));  // R8
endmodule

bind calclk_top calclk_chk #(.LEAD_CYCLES(LEAD_CYCLES)) u_chk (
    .clk(clk), .rst(rst), .uip(uip_w), .freeze(freeze_w), .host_wr(host_wr),
    .cur(cur_q), .uf(uf_q), .af(af_q)
);

// File: tb/calclk_top_bench.sv
`timescale 1ns/1ps
module calclk_top_bench;
    localparam int LEAD = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_1hz = 1'b0;
    logic [3:0] host_addr = '0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct { logic [7:0] exp; string tag; } exp_t;
    exp_t sb[$];

    calclk_top #(.LEAD_CYCLES(LEAD)) u_calclk_top (
        .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .host_addr(host_addr),
        .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .irq(irq)
    );

    always #2.5 clk = ~clk;

    // Monitor: compares read data against the scoreboard away from the edge
    always @(negedge clk) begin
        exp_t it;
        if (sb.size() > 0) begin
            it = sb.pop_front();
            checks++;
            if (host_rdata !== it.exp) begin
                errors++;
                $display("FAIL %s: addr %0d actual 0x%02h expected 0x%02h",
                         it.tag, host_addr, host_rdata, it.exp);
            end
        end
    end

    task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
        @(posedge clk); #1;
        host_addr = a;
        host_rd   = 1'b0;
        sb.push_back('{exp: e, tag: tag});
        wait (sb.size() == 0);
    endtask

    task automatic rdclr(input logic [7:0] e, input string tag);
        @(posedge clk); #1;
        host_addr = 4'd12;
        host_rd   = 1'b1;
        sb.push_back('{exp: e, tag: tag});
        wait (sb.size() == 0);
        @(posedge clk); #1;
        host_rd = 1'b0;
    endtask

    task automatic clr_flags();
        @(posedge clk); #1;
        host_addr = 4'd12;
        host_rd   = 1'b1;
        @(posedge clk); #1;
        host_rd = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        host_addr  = a;
        host_wdata = d;
        host_wr    = 1'b1;
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        checks++;
        if (irq !== e) begin
            errors++;
            $display("FAIL %s: irq actual %0b expected %0b", tag, irq, e);
        end
    endtask

    task automatic do_tick();
        @(posedge clk); #1;
        tick_1hz = 1'b1;
        @(posedge clk); #1;
        tick_1hz = 1'b0;
    endtask

    task automatic upd();
        do_tick();
        repeat (LEAD) @(posedge clk);
        #1;
    endtask

    task automatic set_time(input logic [7:0] h, m, s, wd, md, mo, yr, ctl);
        wr(4'd11, ctl | 8'h80);
        wr(4'd4, h);  wr(4'd2, m);  wr(4'd0, s);
        wr(4'd6, wd); wr(4'd7, md); wr(4'd8, mo); wr(4'd9, yr);
        wr(4'd11, ctl);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        chk_irq(1'b0, "R1");
        rd(4'd0, 8'h00, "R1");  rd(4'd1, 8'h00, "R1");  rd(4'd2, 8'h00, "R1");
        rd(4'd4, 8'h00, "R1");  rd(4'd6, 8'h01, "R1");  rd(4'd7, 8'h01, "R1");
        rd(4'd8, 8'h01, "R1");  rd(4'd9, 8'h00, "R1");  rd(4'd10, 8'h00, "R1");
        rd(4'd11, 8'h02, "R1"); rd(4'd12, 8'h00, "R1");

        // R2 address map round trip
        wr(4'd11, 8'h82);
        wr(4'd0, 8'h11); wr(4'd1, 8'h21); wr(4'd2, 8'h12); wr(4'd3, 8'h22);
        wr(4'd4, 8'h13); wr(4'd5, 8'h23); wr(4'd6, 8'h04); wr(4'd7, 8'h15);
        wr(4'd8, 8'h06); wr(4'd9, 8'h17);
        rd(4'd0, 8'h11, "R2"); rd(4'd1, 8'h21, "R2"); rd(4'd2, 8'h12, "R2");
        rd(4'd3, 8'h22, "R2"); rd(4'd4, 8'h13, "R2"); rd(4'd5, 8'h23, "R2");
        rd(4'd6, 8'h04, "R2"); rd(4'd7, 8'h15, "R2"); rd(4'd8, 8'h06, "R2");
        rd(4'd9, 8'h17, "R2"); rd(4'd11, 8'h82, "R2");
        wr(4'd1, 8'h00); wr(4'd3, 8'h00); wr(4'd5, 8'h00);

        // R11 frozen: tick gives no window and no change
        clr_flags();
        do_tick();
        rd(4'd10, 8'h00, "R11");
        repeat (LEAD + 2) @(posedge clk);
        rd(4'd0, 8'h11, "R11");
        rdclr(8'h00, "R11");

        // R5 R7 full rollover at end of century, alarm 00:00:00 hits (R8, R9)
        set_time(8'h23, 8'h59, 8'h59, 8'h07, 8'h31, 8'h12, 8'h99, 8'h02);
        upd();
        rd(4'd0, 8'h00, "R5"); rd(4'd2, 8'h00, "R5"); rd(4'd4, 8'h00, "R5");
        rd(4'd6, 8'h01, "R7"); rd(4'd7, 8'h01, "R7"); rd(4'd8, 8'h01, "R7");
        rd(4'd9, 8'h00, "R7");
        rdclr(8'h30, "R9");
        rdclr(8'h00, "R10");

        // R5 minute carry only
        set_time(8'h10, 8'h15, 8'h59, 8'h02, 8'h05, 8'h06, 8'h10, 8'h02);
        upd();
        rd(4'd0, 8'h00, "R5"); rd(4'd2, 8'h16, "R5"); rd(4'd4, 8'h10, "R5");

        // R7 month lengths
        set_time(8'h23, 8'h59, 8'h59, 8'h03, 8'h28, 8'h02, 8'h24, 8'h02);
        upd();
        rd(4'd7, 8'h29, "R7"); rd(4'd8, 8'h02, "R7"); rd(4'd6, 8'h04, "R7");
        set_time(8'h23, 8'h59, 8'h59, 8'h03, 8'h29, 8'h02, 8'h24, 8'h02);
        upd();
        rd(4'd7, 8'h01, "R7"); rd(4'd8, 8'h03, "R7");
        set_time(8'h23, 8'h59, 8'h59, 8'h03, 8'h28, 8'h02, 8'h23, 8'h02);
        upd();
        rd(4'd7, 8'h01, "R7"); rd(4'd8, 8'h03, "R7");
        set_time(8'h23, 8'h59, 8'h59, 8'h03, 8'h30, 8'h04, 8'h23, 8'h02);
        upd();
        rd(4'd7, 8'h01, "R7"); rd(4'd8, 8'h05, "R7");

        // R3 binary mode
        set_time(8'h05, 8'h07, 8'h09, 8'h01, 8'h0a, 8'h03, 8'h14, 8'h06);
        upd();
        rd(4'd0, 8'h0a, "R3"); rd(4'd2, 8'h07, "R3"); rd(4'd7, 8'h0a, "R3");
        wr(4'd11, 8'h02);
        rd(4'd0, 8'h10, "R3");
        set_time(8'h05, 8'h07, 8'h3b, 8'h01, 8'h0a, 8'h03, 8'h14, 8'h06);
        upd();
        rd(4'd0, 8'h00, "R3"); rd(4'd2, 8'h08, "R3");

        // R6 twelve-hour mode
        set_time(8'h91, 8'h59, 8'h59, 8'h02, 8'h10, 8'h05, 8'h20, 8'h00);
        upd();
        rd(4'd4, 8'h12, "R6"); rd(4'd7, 8'h11, "R6");
        set_time(8'h11, 8'h59, 8'h59, 8'h02, 8'h10, 8'h05, 8'h20, 8'h00);
        upd();
        rd(4'd4, 8'h92, "R6"); rd(4'd7, 8'h10, "R6");
        set_time(8'h92, 8'h59, 8'h59, 8'h02, 8'h10, 8'h05, 8'h20, 8'h00);
        upd();
        rd(4'd4, 8'h81, "R6");

        // R8 R10 alarm wildcards with alarm interrupt enabled
        clr_flags();
        wr(4'd1, 8'h30); wr(4'd3, 8'hC0); wr(4'd5, 8'hFF);
        set_time(8'h10, 8'h20, 8'h29, 8'h01, 8'h01, 8'h01, 8'h00, 8'h22);
        upd();
        chk_irq(1'b1, "R10");
        rdclr(8'hB0, "R8");
        chk_irq(1'b0, "R10");
        upd();
        rdclr(8'h10, "R8");
        wr(4'd1, 8'h00); wr(4'd3, 8'h21); wr(4'd5, 8'h10);
        set_time(8'h10, 8'h20, 8'h59, 8'h01, 8'h01, 8'h01, 8'h00, 8'h22);
        upd();
        rdclr(8'hB0, "R8");
        wr(4'd5, 8'h11);
        set_time(8'h10, 8'h20, 8'h59, 8'h01, 8'h01, 8'h01, 8'h00, 8'h22);
        upd();
        rdclr(8'h10, "R8");
        wr(4'd11, 8'h12);
        upd();
        chk_irq(1'b1, "R10");
        rdclr(8'h90, "R10");

        // R12 writes in the window
        set_time(8'h08, 8'h00, 8'h10, 8'h01, 8'h01, 8'h01, 8'h00, 8'h02);
        do_tick();
        wr(4'd0, 8'h45);
        wr(4'd1, 8'h07);
        repeat (4) @(posedge clk);
        #1;
        rd(4'd0, 8'h11, "R12"); rd(4'd1, 8'h07, "R12");

        // R10 clear-on-read in the commit cycle
        clr_flags();
        do_tick();
        repeat (LEAD - 2) @(posedge clk);
        rdclr(8'h00, "R10");
        rdclr(8'h10, "R10");

        // R4 tick during the window is ignored
        do_tick();
        do_tick();
        repeat (LEAD - 2) @(posedge clk);
        #1;
        rd(4'd10, 8'h00, "R4");
        rd(4'd0, 8'h13, "R4");
        repeat (12) @(posedge clk);
        rd(4'd0, 8'h13, "R4");

        // R4 window timing
        do_tick();
        rd(4'd0, 8'h13, "R4");
        repeat (LEAD - 3) @(posedge clk);
        rd(4'd10, 8'h80, "R4");
        rd(4'd10, 8'h00, "R4");
        rd(4'd0, 8'h14, "R4");

        // R11 R12 freeze written during a window cancels it
        clr_flags();
        do_tick();
        wr(4'd11, 8'h82);
        rd(4'd10, 8'h00, "R11");
        repeat (12) @(posedge clk);
        rd(4'd0, 8'h14, "R11");
        rdclr(8'h00, "R11");
        wr(4'd11, 8'h02);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule